// File: doc/BRIEF.md
# Flash Query and Identification Read Responder

This block forms the read word that a parallel flash bank returns while it is in query mode or in identification mode. The bank is built from `BANK / DEV` identical devices placed side by side on the data bus. The block first scales the byte address on the bus down to a device-level table index. It then looks up either a byte of the fixed query table or a 16-bit identification code. Finally it copies the per-device answer into every device lane of the bank.

Devices that are natively wider than their active width run in byte mode. For these parts, the query byte is repeated across the device word rather than padded with zeros. An access wider than the bank is built from several successive bank-wide lookups.

The address, access size and mode are captured on each rising clock edge. The read word is a purely combinational function of those captured values. The bank width, active device width, native device width and the table contents are all static parameters.

Top module: `flash_query_resp`

## Requirements
- R1: On every rising edge of `clk`, the block captures `addr_i`, `size_i` and `qry_i`, and `rdata_o` reflects them in the following cycle. While `rst_n` is low, the captured values are address 0, size code 0 and identification mode (`qry_i` = 0).
- R2: The device-level index of a lookup is its bank address shifted right by log2(BANK) + log2(MAXDEV) − log2(DEV).
- R3: The query table holds the following non-zero entries. Index 0x10 = 0x51, 0x11 = 0x52, 0x12 = 0x59 and 0x13 = 0x01. Index 0x27 = log2(BLOCKS × SECTOR_BYTES × DEV / BANK). Index 0x2A = 8 when BANK is 1, and 11 otherwise. Index 0x2C = 0x01. Indices 0x2D and 0x2E hold the low and high byte of BLOCKS − 1. Every other index below 0x52 holds 0.
- R4: A query lookup whose index is 0x52 or above yields zero in its whole bank lane.
- R5: In query mode with DEV equal to MAXDEV, each device lane carries the table byte in its lowest byte and zeros in its other bytes.
- R6: In query mode with DEV below MAXDEV, the outcome depends on DEV. If DEV is 1, every byte of the bank lane equals the table byte. If DEV is greater than 1, the query result is zero.
- R7: In identification mode, only the low 8 bits of the index count. Index 0 selects MANUF_ID and index 1 selects DEVICE_ID. Each device lane holds the low DEV bytes of the 16-bit code, zero-extended. Every other index yields zero.
- R8: Every one of the BANK / DEV device lanes of a bank lane carries the same per-device response.
- R9: Size code 0 is 1 byte, code 1 is 2 bytes, and codes 2 and 3 are 4 bytes. The number of lookups is max(1, bytes / BANK). Lookup k uses bank address `addr + k × BANK`, wrapped to AW bits, and fills bits [8·BANK·k +: 8·BANK]. Bytes above the last lookup are zero.
- R10: If the inputs are held unchanged over consecutive edges outside reset, `rdata_o` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the captured inputs |
| addr_i | input | AW | Byte address of the read on the bank bus |
| size_i | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| qry_i | input | 1 | 1 selects query mode, 0 selects identification mode |
| rdata_o | output | 32 | Assembled read word |

## Verification
The bench builds fourteen copies of the block, one for each legal combination of bank width, active device width and native device width drawn from 1, 2 and 4 bytes. Each copy uses a 10-bit address, 64 blocks of 64 KiB, and fixed identification codes. Sweeping every address under each size code and both modes covers every scaling shift from 0 to 4. It also reaches table indices beyond 0x52, identification indices that wrap at 256, the byte-mode repetition, the unsupported-width zero case, and multi-lookup assembly for narrow banks.

// File: rtl/flash_query_resp.sv
module flash_query_resp #(
  parameter int          BANK         = 4,
  parameter int          MAXDEV       = 2,
  parameter int          DEV          = 1,
  parameter int          AW           = 16,
  parameter int          BLOCKS       = 64,
  parameter int          SECTOR_BYTES = 65536,
  parameter logic [15:0] MANUF_ID     = 16'h0089,
  parameter logic [15:0] DEVICE_ID    = 16'h0018
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          qry_i,
  output logic [31:0]   rdata_o
);

  localparam int LB        = $clog2(BANK);
  localparam int LM        = $clog2(MAXDEV);
  localparam int LD        = $clog2(DEV);
  localparam int SHIFT     = LB + LM - LD;
  localparam int NDEV      = BANK / DEV;
  localparam int LOOKUPS   = 4 / BANK;
  localparam longint DEVSZ = longint'(BLOCKS) * longint'(SECTOR_BYTES / NDEV);
  localparam int LOGSZ     = $clog2(DEVSZ);
  localparam logic [7:0]  WBUF  = (BANK == 1) ? 8'd8 : 8'd11;
  localparam logic [15:0] BLKM1 = 16'(BLOCKS - 1);
  localparam bit BYTE_MODE = DEV < MAXDEV;
  localparam bit BAD_CFG   = BYTE_MODE && (DEV != 1);

  logic [AW-1:0] addr_q;
  logic [1:0]    size_q;
  logic          qry_q;
  int            nbytes, nlook;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      size_q <= '0;
      qry_q  <= 1'b0;
    end else begin
      addr_q <= addr_i;
      size_q <= size_i;
      qry_q  <= qry_i;
    end
  end

  function automatic logic [7:0] qtab(input logic [6:0] i);
    case (i)
      7'h10:   return 8'h51;
      7'h11:   return 8'h52;
      7'h12:   return 8'h59;
      7'h13:   return 8'h01;
      7'h27:   return 8'(LOGSZ);
      7'h2A:   return WBUF;
      7'h2C:   return 8'h01;
      7'h2D:   return BLKM1[7:0];
      7'h2E:   return BLKM1[15:8];
      default: return 8'h00;
    endcase
  endfunction

  always_comb begin
    case (size_q)
      2'd0:    nbytes = 1;
      2'd1:    nbytes = 2;
      default: nbytes = 4;
    endcase
    nlook = (nbytes > BANK) ? (nbytes >> LB) : 1;
  end

  logic [LOOKUPS-1:0][8*BANK-1:0] parts;

  for (genvar k = 0; k < LOOKUPS; k++) begin : g_lk
    logic [AW-1:0] off, idx;
    logic [7:0]    qb;
    logic [31:0]   dv, lane;

    assign off = addr_q + AW'(k * BANK);
    assign idx = off >> SHIFT;
    assign qb  = (idx < AW'(82)) ? qtab(idx[6:0]) : 8'h00;

    always_comb begin
      if (qry_q)
        dv = BAD_CFG ? 32'h0 : (BYTE_MODE ? {4{qb}} : {24'h0, qb});
      else if (idx[7:0] == 8'd0)
        dv = {16'h0, MANUF_ID};
      else if (idx[7:0] == 8'd1)
        dv = {16'h0, DEVICE_ID};
      else
        dv = 32'h0;
      lane = '0;
      for (int j = 0; j < BANK; j++)
        lane[8*j +: 8] = dv[8*(j % DEV) +: 8];
    end

    assign parts[k] = (nlook > k) ? lane[8*BANK-1:0] : '0;

    for (genvar j = DEV; j < BANK; j++) begin : g_rep
      // R8
      lane_repl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[8*BANK*k + 8*j +: 8] == rdata_o[8*BANK*k + 8*(j-DEV) +: 8]);
    end
  end

  assign rdata_o = parts;

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && addr_i == $past(addr_i) && size_i == $past(size_i) && qry_i == $past(qry_i))
    |=> $stable(rdata_o));

  // R4
  qry_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_i && size_i == 2'd0 && (addr_i >> SHIFT) >= AW'(82)) |=> rdata_o[8*BANK-1:0] == '0);

  // R7
  id_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!qry_i && size_i == 2'd0 && ((addr_i >> SHIFT) & AW'(255)) > AW'(1)) |=> rdata_o[8*BANK-1:0] == '0);

  if (BANK < 4) begin : g_hi
    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == 2'd0) |=> rdata_o[31:8*BANK] == '0);
  end

  if (BAD_CFG) begin : g_bad
    // R6
    bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      qry_i |=> rdata_o == 32'h0);
  end

endmodule

// File: tb/test_flash_query_resp.sv
module test_flash_query_resp;
  localparam int NC = 14;
  localparam int AW = 10;
  localparam int BK [NC] = '{1,1,1,2,2,2,2,2,4,4,4,4,4,4};
  localparam int MX [NC] = '{1,2,4,1,2,4,2,4,1,2,4,2,4,4};
  localparam int DV [NC] = '{1,1,1,1,1,1,2,2,1,1,1,2,2,4};
  localparam logic [15:0] MID = 16'h00A7;
  localparam logic [15:0] DID = 16'h5C3E;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr;
  logic [1:0] size;
  logic qry;
  logic [31:0] rd [NC];
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NC; g++) begin : cfg
    flash_query_resp #(.BANK(BK[g]), .MAXDEV(MX[g]), .DEV(DV[g]), .AW(AW),
      .BLOCKS(64), .SECTOR_BYTES(65536), .MANUF_ID(MID), .DEVICE_ID(DID))
      i_flash_query_resp (.clk(clk), .rst_n(rst_n), .addr_i(addr), .size_i(size),
                          .qry_i(qry), .rdata_o(rd[g]));
  end

  function automatic int lg(input int v);
    int r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

  // R3: table entries computed from the requirement
  function automatic int tab(input int i, input int b, input int d);
    case (i)
      16: return 81;
      17: return 82;
      18: return 89;
      19: return 1;
      39: return 22 + lg(d) - lg(b);
      42: return (b == 1) ? 8 : 11;
      44: return 1;
      45: return 63;
      default: return 0;
    endcase
  endfunction

  // R2 shift, R8 lane copies, R9 assembly
  function automatic logic [31:0] model(input int b, input int m, input int d,
                                        input int a, input int sz, input bit q);
    int nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    int nl = (nb > b) ? nb / b : 1;
    int sh = lg(b) + lg(m) - lg(d);
    logic [31:0] r = '0;
    for (int p = 0; p < 4; p++) begin
      int k = p / b;
      int j = p % b;
      int v = 0;
      if (k < nl) begin
        int idx = ((a + k * b) % (1 << AW)) >> sh;
        if (q) begin
          if (idx < 82) begin
            int tb = tab(idx, b, d);
            if (d < m) v = (d == 1) ? tb : 0;
            else v = (j % d == 0) ? tb : 0;
          end
        end else begin
          int i8 = idx % 256;
          int code = (i8 == 0) ? int'(MID) : (i8 == 1) ? int'(DID) : 0;
          v = (j % d < 2) ? (code >> (8 * (j % d))) & 255 : 0;
        end
      end
      r[8*p +: 8] = 8'(v);
    end
    return r;
  endfunction

  function automatic string tag(input int g, input int a, input int sz, input bit q);
    int sh = lg(BK[g]) + lg(MX[g]) - lg(DV[g]);
    if (sz != 0 && (1 << sz) > BK[g]) return "R9";
    if (!q) return "R7";
    if ((a >> sh) >= 82) return "R4";
    if (DV[g] < MX[g]) return "R6";
    if (DV[g] < BK[g]) return "R8";
    return ((a >> sh) < 64) ? "R3" : "R5";
  endfunction

  task automatic check_all(input int a, input int sz, input bit q, input string t);
    for (int g = 0; g < NC; g++) begin
      logic [31:0] e = model(BK[g], MX[g], DV[g], a, sz, q);
      string tg = (t == "") ? tag(g, a, sz, q) : t;
      checks++;
      if (rd[g] !== e) begin
        errors++;
        $display("FAIL %s cfg%0d addr=%0h size=%0d qry=%0d actual=%08h expected=%08h",
                 tg, g, a, sz, q, rd[g], e);
      end
    end
  endtask

  task automatic apply(input int a, input int sz, input bit q);
    addr = AW'(a); size = 2'(sz); qry = q;
    @(posedge clk);
    @(negedge clk);
    check_all(a, sz, q, "");
  endtask

  initial begin
    addr = 10'h155; size = 2'd2; qry = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset holds address 0, size 0, identification mode
    check_all(0, 0, 1'b0, "R1");
    rst_n = 1;
    for (int q = 0; q < 2; q++)
      for (int sz = 0; sz < 4; sz++)
        for (int a = 0; a < (1 << AW); a++)
          apply(a, sz, q[0]);
    // R10: held inputs keep the output steady
    apply(16, 2, 1'b1);
    @(posedge clk); @(negedge clk);
    check_all(16, 2, 1'b1, "R10");
    @(posedge clk); @(negedge clk);
    check_all(16, 2, 1'b1, "R10");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule